// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

The block moves one programmed run of bytes from a read address to a write address. Software fills a small register bank with the source and destination addresses, the byte count (minus one), and the access widths. It can also set burst pacing. A write of the enable bit to the control register starts the run. The engine then alternates one read beat and one write beat on two simple request/acknowledge memory ports until every byte has been moved.

Each address can either advance after every beat or stay fixed, so a device FIFO can be used at either end. Beats are grouped into bursts of a programmed length. When request pacing is on, each burst waits for a peripheral request line before it starts. While a run is active, a live register reports the bytes still to move, minus one. When no run is active it reads as all ones. A cancel bit lets the current beat finish and then stops the run.

Top module: `dma_xfer_engine`

## Requirements
- R1: After reset the engine is idle: no memory request, `busy` low, every configuration register reads zero, and the remaining-size register (offset 0x30) reads 0xFFFFFF.
- R2: Register offsets are 0x00 general config, 0x04 read-port config, 0x08 read address, 0x0C write address, 0x10 size and 0x1C control. Offsets 0x14 and 0x18 read zero. Only implemented bits are stored. General config keeps bits 12, 8, 6:4 and 2:0 (mask 0x1177). Read-port config keeps thread fields 31:28, 27:24 and 19:16, burst field 11:4 and bit 1 (mask 0xFF0F0FF2). Size keeps 23:0.
- R3: Writing control with bit 0 set and bit 20 clear while idle starts a run. The run moves exactly size+1 bytes, with size taken from the 24-bit size field.
- R4: The read width sits in general config bits 2:0 and the write width in bits 6:4. Each is encoded as log2 of the byte count, and codes 3 to 7 mean 8 bytes. Every beat moves the smallest of the read size, the write size and the bytes left. It is one read request and then one write request, each carrying that byte count.
- R5: General config bit 8 makes the read address advance by the beat size after each beat, and bit 12 does the same for the write address. A clear bit keeps that address fixed.
- R6: Read-port bits 11:4 hold the burst length minus one. With read-port bit 1 set, no read request is made before a burst until `periph_req` is sampled high while the engine waits. Without it, bursts follow back to back.
- R7: During a run, offset 0x30 reads the bytes still to move minus one. When idle or finished it reads 0xFFFFFF.
- R8: `done` is high for exactly one cycle, the cycle in which the last write beat is acknowledged. `busy` (also control bit 0) is low on the next cycle.
- R9: Writing control bit 20 during a run lets the beat in progress finish, issues no further request and returns the engine to idle. If the engine is waiting for a peripheral request, it returns to idle at once.
- R10: Writes to configuration registers while a run is active are ignored.
- R11: A read or write request, with its address, holds stable until it is acknowledged. Write data also holds stable until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register byte offset within the channel bank |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| rd_req | output | 1 | Read beat request |
| rd_addr | output | AW | Read beat address |
| rd_bytes | output | 4 | Bytes in the read beat |
| rd_ack | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data | input | 64 | Read data, low bytes significant |
| wr_req | output | 1 | Write beat request |
| wr_addr | output | AW | Write beat address |
| wr_bytes | output | 4 | Bytes in the write beat |
| wr_data | output | 64 | Write data, low bytes significant |
| wr_ack | input | 1 | Write acknowledge |
| periph_req | input | 1 | Peripheral request that paces bursts |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse on the final write acknowledge |

## Verification
Several properties are checked on every clock. Requests must stay held and stable until acknowledged, and no read may start while a paced burst waits for its request. Each accepted write beat must lower the remaining count. The engine must be idle on the cycle after `done`, and after a cancelled beat finishes. Other behaviour can only be shown by the bench's scenarios against a byte-level model, because it depends on the memory contents. These are the exact bytes copied under mixed widths, with fixed or advancing addresses and partial last beats. The same holds for burst-length grouping, the readback value of the remaining-size register partway through a run, and the ignoring of writes made while busy.

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine #(
  parameter int AW = 32,
  parameter int CW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [5:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  output logic [3:0]    rd_bytes,
  input  logic          rd_ack,
  input  logic [63:0]   rd_data,
  output logic          wr_req,
  output logic [AW-1:0] wr_addr,
  output logic [3:0]    wr_bytes,
  output logic [63:0]   wr_data,
  input  logic          wr_ack,
  input  logic          periph_req,
  output logic          busy,
  output logic          done
);
  localparam logic [5:0] A_GEN = 6'h00, A_PORT = 6'h04, A_RADR = 6'h08,
                         A_WADR = 6'h0C, A_SIZE = 6'h10, A_CTRL = 6'h1C,
                         A_LEFT = 6'h30;

  typedef enum logic [1:0] {S_IDLE, S_PACE, S_RD, S_WR} st_t;
  st_t st_q;

  logic [2:0]    rw_q, ww_q;
  logic          rinc_q, winc_q, pace_q, cancel_q;
  logic [7:0]    blen_q, bcnt_q;
  logic [3:0]    tha_q, thb_q, thc_q;
  logic [AW-1:0] raddr_q, waddr_q;
  logic [CW-1:0] size_q;
  logic [CW:0]   left_q;
  logic [63:0]   buf_q;

  function automatic logic [3:0] w2b(input logic [2:0] e);
    return (e >= 3'd3) ? 4'd8 : (4'd1 << e);
  endfunction

  logic [3:0] lim, step;
  assign lim  = (w2b(rw_q) < w2b(ww_q)) ? w2b(rw_q) : w2b(ww_q);
  assign step = (left_q < {{(CW-3){1'b0}}, lim}) ? left_q[3:0] : lim;

  logic cfg_ok, start, cancel_wr, last, beat_done;
  assign busy      = st_q != S_IDLE;
  assign cfg_ok    = reg_wr && !busy;
  assign start     = cfg_ok && reg_addr == A_CTRL && reg_wdata[0] && !reg_wdata[20];
  assign cancel_wr = reg_wr && busy && reg_addr == A_CTRL && reg_wdata[20];
  assign last      = left_q == {{(CW-3){1'b0}}, step};
  assign beat_done = st_q == S_WR && wr_ack;
  assign done      = beat_done && last;

  assign rd_req   = st_q == S_RD;
  assign wr_req   = st_q == S_WR;
  assign rd_addr  = raddr_q;
  assign wr_addr  = waddr_q;
  assign rd_bytes = step;
  assign wr_bytes = step;
  assign wr_data  = buf_q;

  logic [CW:0] left_m1;
  assign left_m1 = left_q - 1'b1;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_GEN:  begin
        reg_rdata[2:0] = rw_q; reg_rdata[6:4] = ww_q;
        reg_rdata[8] = rinc_q; reg_rdata[12] = winc_q;
      end
      A_PORT: begin
        reg_rdata[31:28] = tha_q; reg_rdata[27:24] = thb_q;
        reg_rdata[19:16] = thc_q; reg_rdata[11:4] = blen_q;
        reg_rdata[1] = pace_q;
      end
      A_RADR: reg_rdata = 32'(raddr_q);
      A_WADR: reg_rdata = 32'(waddr_q);
      A_SIZE: reg_rdata[CW-1:0] = size_q;
      A_CTRL: reg_rdata[0] = busy;
      A_LEFT: reg_rdata[CW-1:0] = busy ? left_m1[CW-1:0] : {CW{1'b1}};
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      rw_q <= '0; ww_q <= '0; rinc_q <= 1'b0; winc_q <= 1'b0;
      pace_q <= 1'b0; cancel_q <= 1'b0; blen_q <= '0; bcnt_q <= '0;
      tha_q <= '0; thb_q <= '0; thc_q <= '0;
      raddr_q <= '0; waddr_q <= '0; size_q <= '0; left_q <= '0; buf_q <= '0;
    end else begin
      if (cfg_ok) begin
        case (reg_addr)
          A_GEN: begin
            rw_q <= reg_wdata[2:0]; ww_q <= reg_wdata[6:4];
            rinc_q <= reg_wdata[8]; winc_q <= reg_wdata[12];
          end
          A_PORT: begin
            tha_q <= reg_wdata[31:28]; thb_q <= reg_wdata[27:24];
            thc_q <= reg_wdata[19:16]; blen_q <= reg_wdata[11:4];
            pace_q <= reg_wdata[1];
          end
          A_RADR: raddr_q <= reg_wdata[AW-1:0];
          A_WADR: waddr_q <= reg_wdata[AW-1:0];
          A_SIZE: size_q <= reg_wdata[CW-1:0];
          default: ;
        endcase
      end
      if (cancel_wr) cancel_q <= 1'b1;
      case (st_q)
        S_IDLE: begin
          cancel_q <= 1'b0;
          if (start) begin
            left_q <= {1'b0, size_q} + 1'b1;
            bcnt_q <= '0;
            st_q   <= pace_q ? S_PACE : S_RD;
          end
        end
        S_PACE: begin
          if (cancel_q || cancel_wr) st_q <= S_IDLE;
          else if (periph_req)       st_q <= S_RD;
        end
        S_RD: if (rd_ack) begin
          buf_q <= rd_data;
          st_q  <= S_WR;
        end
        S_WR: if (wr_ack) begin
          left_q <= left_q - {{(CW-3){1'b0}}, step};
          if (rinc_q) raddr_q <= raddr_q + AW'(step);
          if (winc_q) waddr_q <= waddr_q + AW'(step);
          if (last || cancel_q || cancel_wr) st_q <= S_IDLE;
          else if (bcnt_q == blen_q) begin
            bcnt_q <= '0;
            st_q   <= pace_q ? S_PACE : S_RD;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
            st_q   <= S_RD;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_ack |=> rd_req && $stable(rd_addr) && $stable(rd_bytes));
  // R11
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_ack |=> wr_req && $stable(wr_addr) && $stable(wr_data));
  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
  // R6
  pace_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_q == S_PACE && !periph_req |=> !rd_req);
  // R9
  cancel_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_q && wr_req && wr_ack |=> !busy);
  // R7
  left_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_ack && !done |=> left_q < $past(left_q));
endmodule

// File: tb/tb_dma_xfer_engine.sv
`timescale 1ns/1ps
module tb_dma_xfer_engine;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic rd_req, wr_req, rd_ack = 1'b0, wr_ack = 1'b0, periph_req = 1'b0, busy, done;
  logic [31:0] rd_addr, wr_addr;
  logic [3:0] rd_bytes, wr_bytes;
  logic [63:0] rd_data = '0, wr_data;

  always #2.5 clk = ~clk;

  dma_xfer_engine dut (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .rd_req, .rd_addr, .rd_bytes, .rd_ack, .rd_data, .wr_req, .wr_addr, .wr_bytes,
    .wr_data, .wr_ack, .periph_req, .busy, .done);

  logic [7:0] mem [0:1023];
  logic [7:0] exp_m [0:1023];
  int vecs = 0, fails = 0, bytes_wr = 0, beats = 0, done_cnt = 0, exp_total = 0;
  bit done_ok = 1'b1, ack_always = 1'b1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vecs++;
    if (!ok) begin fails++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic wreg(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic int wb(input int e);
    return (e >= 3) ? 8 : (1 << e);
  endfunction

  // memory responder
  initial forever begin
    @(negedge clk);
    rd_ack = 1'b0; wr_ack = 1'b0;
    if (rd_req && (ack_always || $urandom % 4 != 0)) begin
      rd_ack = 1'b1;
      for (int j = 0; j < 8; j++) rd_data[j*8 +: 8] = mem[(rd_addr + j) & 1023];
    end
    if (wr_req && (ack_always || $urandom % 4 != 0)) begin
      wr_ack = 1'b1;
      for (int j = 0; j < int'(wr_bytes); j++) mem[(wr_addr + j) & 1023] = wr_data[j*8 +: 8];
      bytes_wr += int'(wr_bytes); beats++;
      #1 if (done) begin done_cnt++; if (bytes_wr != exp_total) done_ok = 1'b0; end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++; $display("FAIL watchdog act=0 exp=1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  task automatic prog(input int n, input int rw, input int ww, input int ri, input int wi,
                      input int bl, input int pace, input int src, input int dst);
    wreg(6'h00, 32'(rw | (ww << 4) | (ri << 8) | (wi << 12)));
    wreg(6'h04, 32'((bl << 4) | (pace << 1)));
    wreg(6'h08, 32'(src)); wreg(6'h0C, 32'(dst)); wreg(6'h10, 32'(n - 1));
    bytes_wr = 0; beats = 0; done_cnt = 0; done_ok = 1'b1; exp_total = n;
  endtask

  task automatic model(input int n, input int rw, input int ww, input int ri, input int wi,
                       input int src, input int dst);
    int left, ra, wa, k, lim;
    for (int i = 0; i < 1024; i++) exp_m[i] = mem[i];
    left = n; ra = src; wa = dst;
    while (left > 0) begin
      lim = (wb(rw) < wb(ww)) ? wb(rw) : wb(ww);
      k = (left < lim) ? left : lim;
      for (int j = 0; j < k; j++) exp_m[wa + j] = mem[ra + j];
      if (ri != 0) ra += k;
      if (wi != 0) wa += k;
      left -= k;
    end
  endtask

  task automatic run(input string tag, input int n, input int rw, input int ww,
                     input int ri, input int wi, input int bl, input int src, input int dst);
    logic [31:0] v; int bad;
    for (int i = 512; i < 1024; i++) mem[i] = 8'h00;
    model(n, rw, ww, ri, wi, src, dst);
    prog(n, rw, ww, ri, wi, bl, 0, src, dst);
    wreg(6'h1C, 32'h1);
    while (busy) @(negedge clk);
    bad = 0;
    for (int i = 0; i < 1024; i++) if (mem[i] != exp_m[i]) bad++;
    chk(bad == 0, {tag, " R3 R4 R5 data"}, bad, 0);
    chk(done_cnt == 1 && done_ok, {tag, " R8 done"}, done_cnt, 1);
    rreg(6'h30, v);
    chk(v == 32'hFFFFFF, {tag, " R7 idle left"}, v, 32'hFFFFFF);
  endtask

  initial begin
    logic [31:0] v; int b0;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rreg(6'h30, v); chk(v == 32'hFFFFFF, "R1 left", v, 32'hFFFFFF);
    rreg(6'h1C, v); chk(v == 0 && !rd_req && !wr_req && !busy, "R1 ctrl", v, 0);
    rreg(6'h00, v); chk(v == 0, "R1 gen", v, 0);
    // R2 register masks
    wreg(6'h00, 32'hFFFFFFFF); rreg(6'h00, v); chk(v == 32'h1177, "R2 gen", v, 32'h1177);
    wreg(6'h04, 32'hFFFFFFFF); rreg(6'h04, v); chk(v == 32'hFF0F0FF2, "R2 port", v, 32'hFF0F0FF2);
    wreg(6'h10, 32'hFFFFFFFF); rreg(6'h10, v); chk(v == 32'hFFFFFF, "R2 size", v, 32'hFFFFFF);
    wreg(6'h08, 32'h1234_5678); rreg(6'h08, v); chk(v == 32'h1234_5678, "R2 raddr", v, 32'h1234_5678);
    rreg(6'h14, v); chk(v == 0, "R2 gap", v, 0);
    // directed corners
    run("one byte", 1, 2, 2, 1, 1, 0, 10, 600);
    run("partial 8B", 3, 3, 3, 1, 1, 0, 20, 640);
    run("mixed widths", 21, 3, 1, 1, 1, 2, 33, 700);
    run("fixed wr R5", 12, 0, 2, 1, 0, 0, 40, 800);
    run("fixed rd R5", 16, 1, 1, 0, 1, 1, 50, 820);
    run("clamp code R4", 19, 6, 5, 1, 1, 3, 61, 900);
    // R6 R7 R10 pacing
    prog(10, 0, 0, 1, 1, 1, 1, 100, 520);
    wreg(6'h1C, 32'h1);
    repeat (10) @(negedge clk);
    chk(beats == 0, "R6 waits for request", beats, 0);
    rreg(6'h30, v); chk(v == 9, "R7 left before", v, 9);
    wreg(6'h00, 32'h0); rreg(6'h00, v); chk(v == 32'h1100, "R10 gen ignored", v, 32'h1100);
    @(negedge clk); periph_req = 1'b1; @(negedge clk); periph_req = 1'b0;
    repeat (20) @(negedge clk);
    chk(beats == 2, "R6 one burst", beats, 2);
    rreg(6'h30, v); chk(v == 7, "R7 left mid", v, 7);
    // R9 cancel while waiting
    wreg(6'h1C, 32'h100000);
    chk(!busy && beats == 2, "R9 cancel idle", beats, 2);
    rreg(6'h30, v); chk(v == 32'hFFFFFF, "R9 R7 left after cancel", v, 32'hFFFFFF);
    chk(done_cnt == 0, "R8 no done on cancel", done_cnt, 0);
    // R9 cancel mid run
    prog(40, 0, 0, 1, 1, 0, 0, 150, 560);
    wreg(6'h1C, 32'h1);
    repeat (4) @(negedge clk);
    wreg(6'h1C, 32'h100000);
    repeat (3) @(negedge clk);
    b0 = bytes_wr;
    chk(!busy && b0 < 40, "R9 stopped", b0, 40);
    repeat (10) @(negedge clk);
    chk(bytes_wr == b0, "R9 no more writes", bytes_wr, b0);
    // random
    ack_always = 1'b0;
    for (int t = 0; t < 25; t++)
      run("random", 1 + $urandom % 48, $urandom % 8, $urandom % 8, $urandom % 2,
          $urandom % 2, $urandom % 4, $urandom % 128, 512 + $urandom % 128);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule